// File: doc/BRIEF.md
# Interrupt Request Gateway Bank

This block turns each external interrupt request line into one pending bit for a downstream priority arbiter. Sources are numbered 1 to the last source index; there is no source 0. Each source has its own 2-bit control field. The field picks level or edge sensing and the active polarity of the raw line. Each source also has a clear strobe. The strobe is driven by the register decode whenever software writes that source's clear address, whatever data that write carries.

In level mode the pending bit mirrors the polarity-corrected line, with no delay. In edge mode an active edge is caught and held. The pending bit then stays set after the line goes inactive, until the clear strobe removes it. Polarity correction is an exclusive-OR applied before any detection. Edge detection compares the corrected sample with the sample from the cycle before. The asynchronous active-low reset is released through a synchronizer inside the block.

Top module: `irqgw_bank`

## Requirements
- R1: While reset is asserted, and after its release with no active request, every pending output is 0. Edge history resets to the inactive value.
- R2: The control field of source s sits at ctrl_i[2s+1:2s]. The upper bit selects edge (1) or level (0) sensing. The lower bit selects active-low (1) or active-high (0). The value 2'b10 is edge-triggered, active-high.
- R3: In edge mode, a request pulse as short as one cycle sets the pending bit one cycle after the pulse is first sampled. The bit stays set after the line returns inactive.
- R4: In edge mode, a one-cycle clear strobe with no new edge in the same cycle makes the pending bit 0 on the next cycle.
- R5: In edge mode, when a new active edge and a clear strobe arrive in the same cycle, the pending bit is set afterwards.
- R6: In level mode, the pending bit equals the polarity-corrected line in the same cycle. A clear strobe has no lasting effect.
- R7: With active-low polarity in edge mode, a falling raw line sets pending. A rising raw line does not.
- R8: In edge mode, a line held active after a clear does not set pending again; only a new inactive-to-active transition does.
- R9: Sources are independent. A request or a clear on one source leaves every other pending bit unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | LAST_SRC (indices LAST_SRC:1) | Raw request line per source |
| ctrl_i | input | 2*LAST_SRC (indices 2*LAST_SRC+1:2) | Per-source control field {edge, active_low} |
| clr_i | input | LAST_SRC (indices LAST_SRC:1) | Per-source clear strobe from the register decode |
| pend_o | output | LAST_SRC (indices LAST_SRC:1) | Per-source pending bit to the arbiter |

## Verification
A single-cycle pulse in edge mode separates a true latch from a level follower. A line held high across a clear separates edge detection from level re-sampling. A clear that lands in the same cycle as a fresh edge checks that set wins over clear. Level-mode toggling, read in the same cycle, shows that this path has no register. A clear pulse while the level is held shows the clear has no lasting effect there. In active-low edge mode, raw falls and raw rises confirm that polarity is applied before detection. Marker sources left pending while other sources are requested and cleared show that sources do not interfere.

// File: rtl/irqgw_pkg.sv
package irqgw_pkg;
  // Control field layout: bit 1 = edge sensing, bit 0 = active-low polarity
  typedef struct packed {
    logic edge_mode;
    logic active_low;
  } irqgw_cfg_t;

  localparam int unsigned CFG_W = $bits(irqgw_cfg_t);
endpackage

// File: rtl/irqgw_rst_sync.sv
module irqgw_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/irqgw_cell.sv
module irqgw_cell
  import irqgw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_sn,
  input  logic       req,
  input  irqgw_cfg_t cfg,
  input  logic       clr,
  output logic       pend
);
  logic norm;
  logic hist_q, hist_d, hist_en;
  logic latch_q, latch_d, latch_en;
  logic rise;

  // Polarity correction precedes any detection
  always_comb begin
    norm     = req ^ cfg.active_low;
    rise     = norm & ~hist_q;
    hist_d   = norm;
    hist_en  = (hist_q != norm);
    // New edge wins over a simultaneous clear; level mode keeps latch empty
    latch_d  = cfg.edge_mode & (rise | (latch_q & ~clr));
    latch_en = (latch_d != latch_q);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)      hist_q <= 1'b0;
    else if (hist_en) hist_q <= hist_d;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)       latch_q <= 1'b0;
    else if (latch_en) latch_q <= latch_d;
  end

  assign pend = cfg.edge_mode ? latch_q : norm;
endmodule

// File: rtl/irqgw_bank.sv
module irqgw_bank
  import irqgw_pkg::*;
#(
  parameter int unsigned LAST_SRC    = 31,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [LAST_SRC:1]         req_i,
  input  logic [CFG_W*LAST_SRC+1:2] ctrl_i,
  input  logic [LAST_SRC:1]         clr_i,
  output logic [LAST_SRC:1]         pend_o
);
  logic rst_sync_n;

  irqgw_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar s = 1; s <= LAST_SRC; s++) begin : g_src
    irqgw_cfg_t cfg_s;
    assign cfg_s = irqgw_cfg_t'(ctrl_i[CFG_W*s+1 -: CFG_W]);

    irqgw_cell u_cell (
      .clk    (clk),
      .rst_sn (rst_sync_n),
      .req    (req_i[s]),
      .cfg    (cfg_s),
      .clr    (clr_i[s]),
      .pend   (pend_o[s])
    );
  end
endmodule

// File: rtl/irqgw_bank_chk.sv
module irqgw_bank_chk #(
  parameter int unsigned LAST_SRC = 31
) (
  input logic                  clk,
  input logic                  rst_sn,
  input logic [LAST_SRC:1]     req_i,
  input logic [2*LAST_SRC+1:2] ctrl_i,
  input logic [LAST_SRC:1]     clr_i,
  input logic [LAST_SRC:1]     pend_o
);
  for (genvar s = 1; s <= LAST_SRC; s++) begin : g_chk
    logic edg, lvl, prev_q;
    assign edg = ctrl_i[2*s+1];
    assign lvl = req_i[s] ^ ctrl_i[2*s];

    always_ff @(posedge clk or negedge rst_sn) begin
      if (!rst_sn) prev_q <= 1'b0;
      else         prev_q <= lvl;
    end

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_sn)
      (edg && pend_o[s] && !clr_i[s]) |=> (!ctrl_i[2*s+1] || pend_o[s]));

    assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_sn)
      (edg && clr_i[s] && !(lvl && !prev_q)) |=> (!ctrl_i[2*s+1] || !pend_o[s]));

    assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_sn)
      (edg && clr_i[s] && lvl && !prev_q) |=> (!ctrl_i[2*s+1] || pend_o[s]));

    assert_level_follow_R6: assert property (@(posedge clk) disable iff (!rst_sn)
      !edg |-> (pend_o[s] == lvl));

    assert_no_reedge_R8: assert property (@(posedge clk) disable iff (!rst_sn)
      (edg && !pend_o[s] && !(lvl && !prev_q)) |=> (!ctrl_i[2*s+1] || !pend_o[s]));
  end
endmodule

bind irqgw_bank irqgw_bank_chk #(.LAST_SRC(LAST_SRC)) u_chk (
  .clk    (clk),
  .rst_sn (rst_sync_n),
  .req_i  (req_i),
  .ctrl_i (ctrl_i),
  .clr_i  (clr_i),
  .pend_o (pend_o)
);

// File: tb/irqgw_bank_test.sv
module irqgw_bank_test;
  localparam int unsigned LAST_SRC = 31;

  logic                  clk;
  logic                  rst_n;
  logic [LAST_SRC:1]     req_i;
  logic [2*LAST_SRC+1:2] ctrl_i;
  logic [LAST_SRC:1]     clr_i;
  logic [LAST_SRC:1]     pend_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  irqgw_bank #(.LAST_SRC(LAST_SRC)) uut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i),
    .ctrl_i(ctrl_i), .clr_i(clr_i), .pend_o(pend_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(string req, logic [LAST_SRC:1] act, logic [LAST_SRC:1] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: pend_o actual %h expected %h", req, act, exp);
    end
  endtask

  // Advance n cycles; drive/sample just after the falling edge
  task automatic cyc(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  function automatic logic [LAST_SRC:1] bitv(int s);
    logic [LAST_SRC:1] v = '0;
    v[s] = 1'b1;
    return v;
  endfunction

  task automatic t_reset();
    check("R1 during reset", pend_o, '0);
    rst_n = 1'b1;
    cyc(4);
    check("R1 after release", pend_o, '0);
  endtask

  task automatic t_edge_pulse();
    req_i[3] = 1'b1;
    cyc(1);
    req_i[3] = 1'b0;
    check("R3 R2 pulse latched", pend_o, bitv(3));
    cyc(3);
    check("R3 held after line low", pend_o, bitv(3));
  endtask

  task automatic t_clear();
    req_i[7] = 1'b1;
    cyc(1);
    req_i[7] = 1'b0;
    check("R9 second source set", pend_o, bitv(3) | bitv(7));
    clr_i[3] = 1'b1;
    cyc(1);
    clr_i[3] = 1'b0;
    check("R4 R9 clear one source", pend_o, bitv(7));
    cyc(2);
    check("R4 stays cleared", pend_o, bitv(7));
  endtask

  task automatic t_held();
    req_i[5] = 1'b1;
    cyc(1);
    check("R3 held line latches", pend_o, bitv(7) | bitv(5));
    clr_i[5] = 1'b1;
    cyc(1);
    clr_i[5] = 1'b0;
    check("R8 clear while held", pend_o, bitv(7));
    cyc(3);
    check("R8 no relatch while held", pend_o, bitv(7));
    req_i[5] = 1'b0;
    cyc(1);
    req_i[5] = 1'b1;
    cyc(1);
    check("R8 new edge relatches", pend_o, bitv(7) | bitv(5));
    req_i[5] = 1'b0;
    clr_i[5] = 1'b1;
    cyc(1);
    clr_i[5] = 1'b0;
  endtask

  task automatic t_collide();
    req_i[9] = 1'b1;
    clr_i[9] = 1'b1;
    cyc(1);
    clr_i[9] = 1'b0;
    req_i[9] = 1'b0;
    check("R5 edge beats clear", pend_o, bitv(7) | bitv(9));
    clr_i[9] = 1'b1;
    cyc(1);
    clr_i[9] = 1'b0;
  endtask

  task automatic t_level();
    ctrl_i[2*11+1 -: 2] = 2'b00;
    #1;
    check("R6 level idle", pend_o, bitv(7));
    req_i[11] = 1'b1;
    #1;
    check("R6 level follows same cycle", pend_o, bitv(7) | bitv(11));
    clr_i[11] = 1'b1;
    cyc(1);
    clr_i[11] = 1'b0;
    cyc(1);
    check("R6 clear has no effect", pend_o, bitv(7) | bitv(11));
    req_i[11] = 1'b0;
    #1;
    check("R6 level drops", pend_o, bitv(7));
    ctrl_i[2*11+1 -: 2] = 2'b01;
    #1;
    check("R2 R6 level active-low", pend_o, bitv(7) | bitv(11));
    req_i[11] = 1'b1;
    #1;
    check("R6 active-low inactive", pend_o, bitv(7));
  endtask

  task automatic t_low_edge();
    req_i[13] = 1'b1;
    ctrl_i[2*13+1 -: 2] = 2'b11;
    cyc(2);
    check("R7 raw high idle", pend_o, bitv(7));
    req_i[13] = 1'b0;
    cyc(1);
    check("R7 raw fall latches", pend_o, bitv(7) | bitv(13));
    clr_i[13] = 1'b1;
    cyc(1);
    clr_i[13] = 1'b0;
    req_i[13] = 1'b1;
    cyc(2);
    check("R7 raw rise ignored", pend_o, bitv(7));
  endtask

  initial begin
    rst_n = 1'b0;
    req_i = '0;
    clr_i = '0;
    for (int s = 1; s <= LAST_SRC; s++) ctrl_i[2*s+1 -: 2] = 2'b10;
    cyc(3);
    t_reset();
    t_edge_pulse();
    t_clear();
    t_held();
    t_collide();
    t_level();
    t_low_edge();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule